// File: doc/BRIEF.md
# GF(2^8) Dual Parity Accumulator

This block computes two parity blocks in a single pass over a set of equal-length source blocks, as needed for RAID5 and RAID6 stripes. Each source block is presented as `BLOCK_BEATS` consecutive beats of `LANES` bytes, one source after another. With every beat the caller supplies two coefficients, one for the P lane and one for the Q lane. Each lane multiplies the incoming bytes by its coefficient in GF(2^8) and XORs the product into a local buffer of one block. A P-lane coefficient of 1 on every source gives plain XOR parity. Per-source Q-lane coefficients give Reed-Solomon style syndrome parity.

The reduction polynomial has an implied x^8 term. Its low eight bits sit in a register that is written while the block is idle. An operation starts with a pulse on `start` that carries the source count minus one. It ends with a one-cycle `done` pulse. After that, both result blocks can be read row by row through a combinational read port. They stay there until the next operation begins.

A Q-only result from a single source is obtained by sending that source twice, with coefficient 0 on the second copy. An earlier operation can be extended by appending its old P and old Q blocks as extra sources: old P with P/Q coefficients (1,0), then old Q with (0,0), then old Q again with (0,1).

Top module: `gfpar_dual`

## Requirements
- R1: After reset, `busy` and `done` are 0 and the polynomial register holds 0x1D, meaning x^8+x^4+x^3+x^2+1.
- R2: The P result is the XOR over all sources of coef_p times the source byte in GF(2^8). With every coef_p equal to 1 it is the plain XOR of the sources.
- R3: The Q result is the XOR over all sources of coef_q times the source byte in GF(2^8), reduced by the programmed polynomial. Byte lane k of a beat occupies bits [8k+7:8k].
- R4: A write on `poly_we` while idle replaces the low eight bits of the polynomial, and later operations reduce by 0x100 OR that value.
- R5: A polynomial write while `busy` is high is ignored.
- R6: `src_cnt_m1` is the number of sources minus one, for 2 to 16 sources. A start with the field at 0 is ignored: `busy` stays low, no `done` is produced and the result buffers are untouched.
- R7: Beat r (0-based) of every source updates result row r. A cycle with `beat_valid` low changes nothing, whatever the data inputs carry.
- R8: `done` is high for exactly one cycle, in the cycle after the last beat of the last source is accepted. `busy` is low in that same cycle. The results then hold, even under idle beats, until the next accepted start.
- R9: A `start` while `busy` is high is ignored, and the running operation keeps its source count.
- R10: Continuing an operation (appending old P with coefficients (1,0), old Q with (0,0) and old Q with (0,1)) gives the same P and Q as one pass over all the data sources.
- R11: A single source sent twice, with Q coefficients (c,0), yields Q = c times that source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| poly_we | input | 1 | Polynomial write strobe, honoured only when idle |
| poly_wdata | input | 8 | Low eight bits of the reduction polynomial |
| start | input | 1 | Begin an operation; honoured only when idle and the count field is non-zero |
| src_cnt_m1 | input | 4 | Number of sources minus one |
| beat_valid | input | 1 | A beat is present on the data and coefficient inputs |
| beat_data | input | LANES*8 | Source bytes of the beat, lane k at bits [8k+7:8k] |
| coef_p | input | 8 | P-lane coefficient of the current source |
| coef_q | input | 8 | Q-lane coefficient of the current source |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse when the results are complete |
| rd_row | input | log2(BLOCK_BEATS) | Result row to read |
| p_rd | output | LANES*8 | P result row selected by rd_row |
| q_rd | output | LANES*8 | Q result row selected by rd_row |

## Verification
A wrong beat or source counter shows up at once in when `done` fires. The pulse comes a beat early or late, or never comes, within the length of one operation. A bad first-source flag, row index or multiplier stage corrupts the result bytes. These appear on the read port as soon as `done` has been seen. A polynomial register that accepts a write while busy shows as wrong Q bytes for operations that use high-order coefficients. The sweep walks every coefficient value against a rotating set of data bytes, so any faulty reduction stage is seen within a few hundred operations.

// File: rtl/gfpar_pkg.sv
package gfpar_pkg;
   localparam int GF_W = 8;
   localparam int MAX_SRC = 16;
   localparam int CNT_W = $clog2(MAX_SRC);
   localparam logic [GF_W-1:0] POLY_RESET = 8'h1D;
   typedef logic [GF_W-1:0] gf_t;
endpackage

// File: rtl/gfpar_mul.sv
module gfpar_mul
   import gfpar_pkg::*;
(
   input  gf_t a_i,
   input  gf_t b_i,
   input  gf_t poly_i,
   output gf_t prod_o
);
   gf_t sh  [GF_W];
   gf_t acc [GF_W+1];

   assign sh[0]  = a_i;
   assign acc[0] = '0;

   for (genvar i = 0; i < GF_W; i++) begin : g_stage
      assign acc[i+1] = acc[i] ^ (b_i[i] ? sh[i] : '0);
      if (i < GF_W - 1) begin : g_shift
         assign sh[i+1] = {sh[i][GF_W-2:0], 1'b0} ^ (sh[i][GF_W-1] ? poly_i : '0);
      end
   end

   assign prod_o = acc[GF_W];
endmodule

// File: rtl/gfpar_lane.sv
module gfpar_lane
   import gfpar_pkg::*;
(
   input  gf_t  src_i,
   input  gf_t  cp_i,
   input  gf_t  cq_i,
   input  gf_t  poly_i,
   input  gf_t  p_old_i,
   input  gf_t  q_old_i,
   input  logic first_i,
   output gf_t  p_new_o,
   output gf_t  q_new_o
);
   gf_t p_prod, q_prod;

   gfpar_mul u_pmul (.a_i(src_i), .b_i(cp_i), .poly_i(poly_i), .prod_o(p_prod));
   gfpar_mul u_qmul (.a_i(src_i), .b_i(cq_i), .poly_i(poly_i), .prod_o(q_prod));

   assign p_new_o = first_i ? p_prod : (p_prod ^ p_old_i);
   assign q_new_o = first_i ? q_prod : (q_prod ^ q_old_i);
endmodule

// File: rtl/gfpar_seq.sv
module gfpar_seq
   import gfpar_pkg::*;
#(
   parameter int BEATS = 4,
   localparam int RW = $clog2(BEATS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic             beat_valid_i,
   output logic             busy_o,
   output logic             done_o,
   output logic             accept_o,
   output logic             first_o,
   output logic [RW-1:0]    row_o
);
   localparam logic [RW-1:0] LAST_ROW = RW'(BEATS - 1);

   logic             busy_q, done_q;
   logic [CNT_W-1:0] src_q, cnt_q;
   logic [RW-1:0]    row_q;
   logic             accept, last_beat;

   assign accept    = busy_q && beat_valid_i;
   assign last_beat = accept && (row_q == LAST_ROW) && (src_q == cnt_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         src_q  <= '0;
         cnt_q  <= '0;
         row_q  <= '0;
      end else begin
         done_q <= last_beat;
         if (!busy_q) begin
            if (start_i && (cnt_i != '0)) begin
               busy_q <= 1'b1;
               cnt_q  <= cnt_i;
               src_q  <= '0;
               row_q  <= '0;
            end
         end else if (accept) begin
            if (row_q == LAST_ROW) begin
               row_q <= '0;
               src_q <= src_q + 1'b1;
            end else begin
               row_q <= row_q + 1'b1;
            end
            if (last_beat) busy_q <= 1'b0;
         end
      end
   end

   assign busy_o   = busy_q;
   assign done_o   = done_q;
   assign accept_o = accept;
   assign first_o  = (src_q == '0);
   assign row_o    = row_q;

   // R6
   zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy_q && start_i && cnt_i == '0) |=> !busy_q);
   // R9
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start_i) |=> (cnt_q == $past(cnt_q)));
   // R7
   stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !beat_valid_i) |=> ($stable(row_q) && $stable(src_q)));
   // R7
   src_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (src_q <= cnt_q));
   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |-> !busy_q);
endmodule

// File: rtl/gfpar_dual.sv
module gfpar_dual
   import gfpar_pkg::*;
#(
   parameter int LANES = 2,
   parameter int BLOCK_BEATS = 4,
   localparam int DW = LANES * GF_W,
   localparam int RW = $clog2(BLOCK_BEATS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             poly_we,
   input  logic [7:0]       poly_wdata,
   input  logic             start,
   input  logic [CNT_W-1:0] src_cnt_m1,
   input  logic             beat_valid,
   input  logic [DW-1:0]    beat_data,
   input  logic [7:0]       coef_p,
   input  logic [7:0]       coef_q,
   output logic             busy,
   output logic             done,
   input  logic [RW-1:0]    rd_row,
   output logic [DW-1:0]    p_rd,
   output logic [DW-1:0]    q_rd
);
   if (LANES < 1) begin : g_bad_lanes
      $error("gfpar_dual: LANES must be at least 1");
   end
   if (BLOCK_BEATS < 2 || (BLOCK_BEATS & (BLOCK_BEATS - 1)) != 0) begin : g_bad_beats
      $error("gfpar_dual: BLOCK_BEATS must be a power of two of at least 2");
   end

   gf_t           poly_q;
   logic          busy_w, accept_w, first_w;
   logic [RW-1:0] row_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                  poly_q <= POLY_RESET;
      else if (poly_we && !busy_w) poly_q <= poly_wdata;
   end

   gfpar_seq #(.BEATS(BLOCK_BEATS)) u_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start), .cnt_i(src_cnt_m1),
      .beat_valid_i(beat_valid), .busy_o(busy_w), .done_o(done),
      .accept_o(accept_w), .first_o(first_w), .row_o(row_w)
   );

   logic [DW-1:0] p_buf [BLOCK_BEATS];
   logic [DW-1:0] q_buf [BLOCK_BEATS];
   logic [DW-1:0] p_old, q_old, p_nxt, q_nxt;

   assign p_old = p_buf[row_w];
   assign q_old = q_buf[row_w];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      gfpar_lane u_lane (
         .src_i(beat_data[l*GF_W +: GF_W]), .cp_i(coef_p), .cq_i(coef_q),
         .poly_i(poly_q), .p_old_i(p_old[l*GF_W +: GF_W]),
         .q_old_i(q_old[l*GF_W +: GF_W]), .first_i(first_w),
         .p_new_o(p_nxt[l*GF_W +: GF_W]), .q_new_o(q_nxt[l*GF_W +: GF_W])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < BLOCK_BEATS; i++) begin
            p_buf[i] <= '0;
            q_buf[i] <= '0;
         end
      end else if (accept_w) begin
         p_buf[row_w] <= p_nxt;
         q_buf[row_w] <= q_nxt;
      end
   end

   assign p_rd = p_buf[rd_row];
   assign q_rd = q_buf[rd_row];
   assign busy = busy_w;

   // R5
   poly_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_w |=> $stable(poly_q));
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

// File: tb/sim_gfpar_dual.sv
`timescale 1ns/1ps
module sim_gfpar_dual;
   localparam int LN = 2;
   localparam int BB = 4;
   localparam int DW = LN * 8;
   localparam int RW = 2;

   logic clk, rst_n, poly_we, start, beat_valid, busy, done;
   logic [7:0] poly_wdata, coef_p, coef_q;
   logic [3:0] src_cnt_m1;
   logic [DW-1:0] beat_data, p_rd, q_rd;
   logic [RW-1:0] rd_row;

   gfpar_dual #(.LANES(LN), .BLOCK_BEATS(BB)) u0 (
      .clk(clk), .rst_n(rst_n), .poly_we(poly_we), .poly_wdata(poly_wdata),
      .start(start), .src_cnt_m1(src_cnt_m1), .beat_valid(beat_valid),
      .beat_data(beat_data), .coef_p(coef_p), .coef_q(coef_q),
      .busy(busy), .done(done), .rd_row(rd_row), .p_rd(p_rd), .q_rd(q_rd)
   );

   initial clk = 1'b0;
   always #4 clk = ~clk;

   int checks = 0, fails = 0;
   logic [7:0] bpoly = 8'h1D;
   logic [DW-1:0] sd [16][BB];
   logic [7:0] cpv [16], cqv [16];
   int nsrc;
   logic [DW-1:0] exp_p [BB], exp_q [BB];
   logic [DW-1:0] old_p [BB], old_q [BB];

   function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b, input logic [7:0] pl);
      logic [7:0] r;
      r = 8'h00;
      for (int i = 7; i >= 0; i--) begin
         r = {r[6:0], 1'b0} ^ (r[7] ? pl : 8'h00);
         if (b[i]) r = r ^ a;
      end
      return r;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
   endtask

   task automatic compute_exp();
      for (int r = 0; r < BB; r++) begin
         exp_p[r] = '0;
         exp_q[r] = '0;
         for (int s = 0; s < nsrc; s++)
            for (int l = 0; l < LN; l++) begin
               exp_p[r][l*8 +: 8] ^= bmul(sd[s][r][l*8 +: 8], cpv[s], bpoly);
               exp_q[r][l*8 +: 8] ^= bmul(sd[s][r][l*8 +: 8], cqv[s], bpoly);
            end
      end
   endtask

   task automatic check_rows(input string tagp, input string tagq);
      for (int r = 0; r < BB; r++) begin
         rd_row = RW'(r);
         #1;
         chk(p_rd === exp_p[r], tagp, 32'(p_rd), 32'(exp_p[r]));
         chk(q_rd === exp_q[r], tagq, 32'(q_rd), 32'(exp_q[r]));
      end
   endtask

   task automatic set_poly(input logic [7:0] v);
      @(negedge clk);
      poly_we = 1'b1; poly_wdata = v;
      @(negedge clk);
      poly_we = 1'b0;
   endtask

   task automatic run_op(input bit stall, input bit midstart, input bit polywr);
      @(negedge clk);
      start = 1'b1; src_cnt_m1 = 4'(nsrc - 1);
      @(negedge clk);
      start = 1'b0; src_cnt_m1 = '0;
      for (int s = 0; s < nsrc; s++)
         for (int r = 0; r < BB; r++) begin
            if (stall && r == 1) begin
               beat_valid = 1'b0; beat_data = DW'($urandom);
               coef_p = 8'($urandom); coef_q = 8'($urandom);
               @(negedge clk);
            end
            beat_valid = 1'b1; beat_data = sd[s][r];
            coef_p = cpv[s]; coef_q = cqv[s];
            start = (midstart && s == 0 && r == 0);
            src_cnt_m1 = start ? 4'd15 : 4'd0;
            poly_we = (polywr && s == 1 && r == 0);
            poly_wdata = 8'h4D;
            @(negedge clk);
         end
      beat_valid = 1'b0; start = 1'b0; poly_we = 1'b0;
      chk(done === 1'b1 && busy === 1'b0, "R8 done high and busy low after last beat",
          32'({done, busy}), 32'h2);
      if (midstart)
         chk(done === 1'b1, "R9 start while busy left the count unchanged", 32'(done), 32'h1);
      @(negedge clk);
      chk(done === 1'b0, "R8 done lasts one cycle", 32'(done), 32'h0);
   endtask

   task automatic rand_sources(input int n, input bit pones);
      nsrc = n;
      for (int s = 0; s < n; s++) begin
         for (int r = 0; r < BB; r++) sd[s][r] = DW'($urandom);
         cpv[s] = pones ? 8'h01 : 8'($urandom);
         cqv[s] = 8'($urandom);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; poly_we = 1'b0; poly_wdata = '0; start = 1'b0;
      src_cnt_m1 = '0; beat_valid = 1'b0; beat_data = '0;
      coef_p = '0; coef_q = '0; rd_row = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(busy === 1'b0, "R1 busy low after reset", 32'(busy), 32'h0);
      chk(done === 1'b0, "R1 done low after reset", 32'(done), 32'h0);

      // R1 R3 sweep: every coefficient value under the reset polynomial
      for (int b = 0; b < 256; b++) begin
         nsrc = 2;
         for (int r = 0; r < BB; r++)
            for (int l = 0; l < LN; l++)
               sd[0][r][l*8 +: 8] = 8'((b * 8 + r * LN + l) * 5 + b);
         cpv[0] = 8'(b); cqv[0] = 8'(b) ^ 8'h5A;
         for (int r = 0; r < BB; r++) sd[1][r] = DW'($urandom);
         cpv[1] = 8'h00; cqv[1] = 8'h00;
         compute_exp();
         run_op(b % 7 == 3, 1'b0, 1'b0);
         check_rows("R2 P lane sweep, reset polynomial R1", "R3 Q lane sweep, reset polynomial R1");
      end

      // R2 plain XOR over the maximum source count
      rand_sources(16, 1'b1);
      compute_exp();
      run_op(1'b0, 1'b0, 1'b0);
      check_rows("R2 plain XOR P over 16 sources", "R3 Q over 16 sources");

      // R11 single-source Q
      nsrc = 2;
      for (int r = 0; r < BB; r++) begin sd[0][r] = DW'($urandom); sd[1][r] = sd[0][r]; end
      cpv[0] = 8'h01; cpv[1] = 8'h00; cqv[0] = 8'hC3; cqv[1] = 8'h00;
      compute_exp();
      run_op(1'b0, 1'b0, 1'b0);
      check_rows("R11 single-source P", "R11 single-source Q");

      // R4 programmed polynomial
      set_poly(8'h1B);
      bpoly = 8'h1B;
      for (int k = 0; k < 32; k++) begin
         rand_sources(3, 1'b0);
         compute_exp();
         run_op(1'b0, 1'b0, 1'b0);
         check_rows("R4 P with polynomial 0x11B", "R4 Q with polynomial 0x11B");
      end

      // R5 write during busy ignored
      rand_sources(4, 1'b0);
      compute_exp();
      run_op(1'b0, 1'b0, 1'b1);
      check_rows("R5 P with write while busy", "R5 Q with write while busy");
      rand_sources(3, 1'b0);
      compute_exp();
      run_op(1'b0, 1'b0, 1'b0);
      check_rows("R5 P on next op", "R5 Q on next op keeps polynomial");

      // R6 zero count rejected
      @(negedge clk);
      start = 1'b1; src_cnt_m1 = 4'd0;
      @(negedge clk);
      start = 1'b0;
      chk(busy === 1'b0, "R6 start with count field 0 ignored", 32'(busy), 32'h0);
      for (int k = 0; k < 4; k++) begin
         beat_valid = 1'b1; beat_data = DW'($urandom);
         coef_p = 8'hFF; coef_q = 8'hFF;
         @(negedge clk);
         chk(done === 1'b0 && busy === 1'b0, "R6 no done after rejected start",
             32'({done, busy}), 32'h0);
      end
      beat_valid = 1'b0;
      check_rows("R6 P untouched after rejected start", "R6 Q untouched after rejected start");

      // R7 stall cycles
      rand_sources(5, 1'b0);
      compute_exp();
      run_op(1'b1, 1'b0, 1'b0);
      check_rows("R7 P with stall cycles", "R7 Q with stall cycles");

      // R8 results hold under idle beats
      for (int k = 0; k < 4; k++) begin
         beat_valid = 1'b1; beat_data = DW'($urandom);
         coef_p = 8'($urandom); coef_q = 8'($urandom);
         @(negedge clk);
      end
      beat_valid = 1'b0;
      check_rows("R8 P held while idle", "R8 Q held while idle");

      // R9 start while busy
      rand_sources(3, 1'b0);
      compute_exp();
      run_op(1'b0, 1'b1, 1'b0);
      check_rows("R9 P after start while busy", "R9 Q after start while busy");

      // R10 continuation
      rand_sources(5, 1'b1);
      compute_exp();
      for (int r = 0; r < BB; r++) begin old_p[r] = exp_p[r]; old_q[r] = exp_q[r]; end
      for (int r = 0; r < BB; r++) begin sd[10][r] = sd[3][r]; sd[11][r] = sd[4][r]; end
      cpv[10] = cpv[3]; cqv[10] = cqv[3]; cpv[11] = cpv[4]; cqv[11] = cqv[4];
      nsrc = 3;
      run_op(1'b0, 1'b0, 1'b0);
      for (int r = 0; r < BB; r++) begin
         rd_row = RW'(r);
         #1;
         sd[2][r] = p_rd;
         sd[3][r] = q_rd;
         sd[4][r] = q_rd;
      end
      for (int r = 0; r < BB; r++) begin sd[0][r] = sd[10][r]; sd[1][r] = sd[11][r]; end
      cpv[0] = cpv[10]; cqv[0] = cqv[10]; cpv[1] = cpv[11]; cqv[1] = cqv[11];
      cpv[2] = 8'h01; cqv[2] = 8'h00;
      cpv[3] = 8'h00; cqv[3] = 8'h00;
      cpv[4] = 8'h00; cqv[4] = 8'h01;
      nsrc = 5;
      run_op(1'b0, 1'b0, 1'b0);
      for (int r = 0; r < BB; r++) begin exp_p[r] = old_p[r]; exp_q[r] = old_q[r]; end
      check_rows("R10 continued P equals single pass", "R10 continued Q equals single pass");

      summary();
      $finish;
   end
endmodule